// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

The block supervises software by way of a 7-bit down-counter that never stops running. Software must reload the counter at regular intervals, but only inside a permitted window. A reload that comes too soon, while the counter is still above a programmed window limit, is treated as a fault. A reload that never comes lets the counter fall from 0x40 to 0x3F, which is also a fault. Either fault gives a one-cycle system reset request, but only once the watchdog has been armed. Arming is permanent until a system reset.

The counter steps down once every `DIV_BASE * 2^tb` clock cycles. `DIV_BASE` is 4096 in silicon and can be set small for simulation. `tb` is a 2-bit time-base field. When the counter steps down into 0x40, a warning flag is set, one step before the timeout. The flag drives an interrupt output if the warning enable is set, so software can log data or reload the counter in time.

Software reaches the three registers through a simple port: valid, write, address and write data, with combinational read data. A small guard state machine owns the arming state and the reset pulse. Its states are DISARMED, ARMED and TRIP. Its transitions are:
- arm: DISARMED to ARMED on a control write with the activation bit set and bit 6 set.
- arm-and-fire: DISARMED to TRIP on a control write with the activation bit set and bit 6 clear.
- fire: ARMED to TRIP on an early reload, a reload with bit 6 clear, or a rollover.
- recover: TRIP to ARMED after one cycle.

Top module: `win_watchdog`

## Requirements
- R1: After reset, a read of the control register (offset 0x0) returns 0x7F, with the activation bit at bit 7 and the counter at bits 6:0. A read of the configuration register (offset 0x4) returns 0x7F, with the warning enable at bit 9, the time base at bits 8:7 and the window at bits 6:0. A read of the status register (offset 0x8) returns 0, with the flag at bit 0. All other bits read as 0.
- R2: The counter decrements once every DIV_BASE * 2^tb cycles, with tb = 0, 1, 2, 3 giving multipliers 1, 2, 4, 8. It keeps running while the watchdog is disarmed.
- R3: A control write loads bits 6:0 of the write data into the counter. The prescaler is not cleared by this write.
- R4: A control write with bit 7 set arms the watchdog. While armed, writing bit 7 as 0 does not disarm it, and the activation read-back stays 1.
- R5: While armed, the step from 0x40 to 0x3F raises the reset request in the cycle after that step.
- R6: While armed, a control write raises the reset request if the current counter is greater than the window. If the counter is equal to or below the window, the write does not.
- R7: A control write with bit 7 set and bit 6 clear raises the reset request, including when that same write is the one that arms the watchdog.
- R8: While disarmed, neither a rollover nor any control write raises the reset request.
- R9: When the counter steps down into 0x40, the status flag is set, whether or not the warning enable is set.
- R10: The interrupt output equals the flag ANDed with the warning enable. Once the enable is set, only a system reset clears it.
- R11: Writing 0 to status bit 0 clears the flag. Writing 1 to it leaves the flag unchanged.
- R12: The reset request is a registered pulse that lasts exactly one cycle. The guard then returns to ARMED, and any trigger in the pulse cycle itself is absorbed by that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_valid | input | 1 | Register access valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| sys_rst_req | output | 1 | One-cycle reset request |
| early_irq | output | 1 | Early-warning interrupt |

## Verification
The bench reloads the counter exactly at 0x51 and at 0x50 with the window at 0x50. A comparator that used >= instead of > would fire on the legal 0x50 reload, and one that used < would miss the 0x51 fault. It fires the software-reset path on the very write that arms the guard. A guard that checked the activation bit held before the write would miss that reset. It times decrements over whole prescaler periods at three time-base settings, so a wrong shift amount shows up as a wrong count. It checks that the warning flag sets with the interrupt disabled, that writing 1 leaves the flag set, and that the enable survives an attempt to write it back to 0. A block that treated these as plain writable bits would show the wrong read-back or interrupt level.

// File: rtl/wwd_pkg.sv
`timescale 1ns/1ps
package wwd_pkg;
    localparam int CNT_W = 7;
    localparam int TB_W  = 2;
    localparam logic [CNT_W-1:0] CNT_WARN = CNT_W'(1 << (CNT_W - 1));

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_CFG  = 4'h4;
    localparam logic [3:0] OFS_STAT = 4'h8;

    typedef enum logic [1:0] {
        WG_DISARMED = 2'd0,
        WG_ARMED    = 2'd1,
        WG_TRIP     = 2'd2
    } guard_state_e;
endpackage

// File: rtl/wwd_prescaler.sv
`timescale 1ns/1ps
module wwd_prescaler #(
    parameter int DIV_BASE = 4096
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [wwd_pkg::TB_W-1:0] tb,
    output logic                     tick
);
    localparam int PW     = $clog2(DIV_BASE * 8);
    localparam int SPAN_W = PW + 1;

    logic [PW-1:0]     pre_q;
    logic [SPAN_W-1:0] span;
    logic [PW-1:0]     limit;

    always_comb begin
        span  = SPAN_W'(DIV_BASE) << tb;
        limit = PW'(span - SPAN_W'(1));
    end

    assign tick = (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + PW'(1);
    end

    // R2: two steps never come on back-to-back cycles (DIV_BASE >= 2)
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wwd_regs.sv
`timescale 1ns/1ps
module wwd_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_valid,
    input  logic                         bus_write,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [wwd_pkg::CNT_W+2:0]    wr_bits,
    input  logic                         tick,
    input  logic                         active,
    output logic                         ctrl_wr,
    output logic [wwd_pkg::CNT_W-1:0]    cnt,
    output logic [wwd_pkg::CNT_W-1:0]    window,
    output logic [wwd_pkg::TB_W-1:0]     tb,
    output logic [DATA_W-1:0]            rdata,
    output logic                         irq
);
    import wwd_pkg::*;

    logic cfg_wr, stat_wr;
    logic ewi_en, flag;

    assign ctrl_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_CTRL));
    assign cfg_wr  = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_CFG));
    assign stat_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_STAT));

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '1;
        else if (ctrl_wr) cnt <= wr_bits[CNT_W-1:0];
        else if (tick)    cnt <= cnt - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window <= '1;
            tb     <= '0;
            ewi_en <= 1'b0;
        end else if (cfg_wr) begin
            window <= wr_bits[CNT_W-1:0];
            tb     <= wr_bits[CNT_W +: TB_W];
            ewi_en <= ewi_en | wr_bits[CNT_W+TB_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (tick && !ctrl_wr && cnt == CNT_WARN + CNT_W'(1))
            flag <= 1'b1;
        else if (stat_wr && !wr_bits[0])
            flag <= 1'b0;
    end

    assign irq = flag & ewi_en;

    always_comb begin
        rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL))
            rdata = {{(DATA_W-CNT_W-1){1'b0}}, active, cnt};
        else if (bus_addr == ADDR_W'(OFS_CFG))
            rdata = {{(DATA_W-CNT_W-TB_W-1){1'b0}}, ewi_en, tb, window};
        else if (bus_addr == ADDR_W'(OFS_STAT))
            rdata = {{(DATA_W-1){1'b0}}, flag};
    end

    // R3: a control write loads the written count
    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> cnt == $past(wr_bits[CNT_W-1:0]));
    // R9: stepping into the warning value sets the flag
    assert_warn_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl_wr && cnt == CNT_WARN + CNT_W'(1)) |=> flag);
    // R10: the warning enable is sticky
    assert_ewi_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ewi_en |=> ewi_en);
    // R11: writing 1 to the flag never clears it
    assert_flag_w1_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && stat_wr && wr_bits[0]) |=> flag);
endmodule

// File: rtl/wwd_guard.sv
`timescale 1ns/1ps
module wwd_guard (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctrl_wr,
    input  logic                      wr_act,
    input  logic                      wr_t6,
    input  logic                      tick,
    input  logic [wwd_pkg::CNT_W-1:0] cnt,
    input  logic [wwd_pkg::CNT_W-1:0] window,
    output logic                      active,
    output logic                      rst_req
);
    import wwd_pkg::*;

    guard_state_e state_q, state_d;
    logic early, swrst, roll, fire;

    always_comb begin
        early = ctrl_wr && (cnt > window);
        swrst = ctrl_wr && !wr_t6;
        roll  = tick && !ctrl_wr && (cnt == CNT_WARN);
        fire  = early || swrst || roll;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WG_DISARMED: begin
                if (ctrl_wr && wr_act)
                    state_d = wr_t6 ? WG_ARMED : WG_TRIP;
            end
            WG_ARMED: begin
                if (fire) state_d = WG_TRIP;
            end
            WG_TRIP: begin
                state_d = WG_ARMED;
            end
            default: state_d = WG_DISARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WG_DISARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        active  = (state_q != WG_DISARMED);
        rst_req = (state_q == WG_TRIP);
    end

    // R12: the reset request never lasts two cycles
    assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R4: arming is permanent until system reset
    assert_arm_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> active);
    // R5: rollover while armed gives a request
    assert_rollover_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !rst_req && tick && !ctrl_wr && cnt == CNT_WARN) |=> rst_req);
    // R6: early reload while armed gives a request
    assert_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !rst_req && ctrl_wr && cnt > window) |=> rst_req);
    // R8: disarmed and untouched stays quiet
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !ctrl_wr) |=> !rst_req);
endmodule

// File: rtl/win_watchdog.sv
`timescale 1ns/1ps
module win_watchdog #(
    parameter int DIV_BASE = 4096,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_rst_req,
    output logic              early_irq
);
    import wwd_pkg::*;

    localparam int WB = CNT_W + TB_W + 1;

    logic                ctrl_wr, tick, active;
    logic [CNT_W-1:0]    cnt, window;
    logic [TB_W-1:0]     tb;
    logic                unused_hi;

    assign unused_hi = &{1'b0, bus_wdata[DATA_W-1:WB]};

    wwd_prescaler #(.DIV_BASE(DIV_BASE)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tb   (tb),
        .tick (tick)
    );

    wwd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .wr_bits  (bus_wdata[WB-1:0]),
        .tick     (tick),
        .active   (active),
        .ctrl_wr  (ctrl_wr),
        .cnt      (cnt),
        .window   (window),
        .tb       (tb),
        .rdata    (bus_rdata),
        .irq      (early_irq)
    );

    wwd_guard u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_wr(ctrl_wr),
        .wr_act (bus_wdata[CNT_W]),
        .wr_t6  (bus_wdata[CNT_W-1]),
        .tick   (tick),
        .cnt    (cnt),
        .window (window),
        .active (active),
        .rst_req(sys_rst_req)
    );
endmodule

// File: tb/tb_win_watchdog.sv
`timescale 1ns/1ps
module tb_win_watchdog;
    localparam int DW = 32;
    localparam logic [3:0] A_CTRL = 4'h0, A_CFG = 4'h4, A_STAT = 4'h8;
    localparam int NV = 5;
    localparam logic [31:0] VEC_IN  [NV] = '{32'h0000_0050, 32'h0000_01B0,
                                            32'hFFFF_F9AA, 32'h0000_00FF, 32'h0000_007F};
    localparam logic [31:0] VEC_OUT [NV] = '{32'h0000_0050, 32'h0000_01B0,
                                            32'h0000_01AA, 32'h0000_00FF, 32'h0000_007F};

    logic clk = 0, rst_n = 0;
    logic bus_valid = 0, bus_write = 0;
    logic [3:0] bus_addr = 0;
    logic [DW-1:0] bus_wdata = 0, bus_rdata;
    logic sys_rst_req, early_irq;
    int n_chk = 0, n_fail = 0, pulses = 0;
    bit done = 0;

    always #2 clk = ~clk;

    win_watchdog #(.DIV_BASE(4), .DATA_W(DW), .ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_rst_req(sys_rst_req), .early_irq(early_irq));

    always @(posedge clk) if (sys_rst_req === 1'b1) pulses <= pulses + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, a, e);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_write = 0; bus_valid = 1;
        #0.1;
        d = bus_rdata;
        bus_valid = 0;
    endtask

    task automatic wait_cnt(input logic [6:0] t, output bit hit);
        logic [31:0] v;
        hit = 0;
        for (int i = 0; i < 3000 && !hit; i++) begin
            @(negedge clk);
            rd(A_CTRL, v);
            if (v[6:0] == t) hit = 1;
        end
    endtask

    task automatic poll_write(input logic [6:0] t, input logic [31:0] d, output bit hit);
        logic [31:0] v;
        hit = 0;
        for (int i = 0; i < 3000 && !hit; i++) begin
            @(negedge clk);
            rd(A_CTRL, v);
            if (v[6:0] == t) begin
                bus_valid = 1; bus_write = 1; bus_addr = A_CTRL; bus_wdata = d;
                @(negedge clk);
                bus_valid = 0; bus_write = 0;
                hit = 1;
            end
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit hit;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values
        rd(A_CTRL, v); chk(v == 32'h7F, "R1 ctrl reset", v, 32'h7F);
        rd(A_CFG,  v); chk(v == 32'h7F, "R1 cfg reset", v, 32'h7F);
        rd(A_STAT, v); chk(v == 32'h0,  "R1 stat reset", v, 0);
        chk(sys_rst_req == 0 && early_irq == 0, "R1 outputs idle", {sys_rst_req, early_irq}, 0);

        // R1: configuration layout, reserved bits read 0
        for (int i = 0; i < NV; i++) begin
            wr(A_CFG, VEC_IN[i]);
            rd(A_CFG, v);
            chk(v == VEC_OUT[i], "R1 cfg vector", v, VEC_OUT[i]);
        end

        // R2 R3: decrement rate for three time bases, counter load
        wr(A_CTRL, 32'h65); rd(A_CTRL, v);
        chk(v == 32'h65, "R3 load", v, 32'h65);
        wr(A_CFG, 32'h07F); repeat (40) @(negedge clk);
        wr(A_CTRL, 32'h7F); repeat (20) @(negedge clk); rd(A_CTRL, v);
        chk(v == 32'h7A, "R2 tb0 rate", v, 32'h7A);
        wr(A_CFG, 32'h17F); repeat (40) @(negedge clk);
        wr(A_CTRL, 32'h7F); repeat (48) @(negedge clk); rd(A_CTRL, v);
        chk(v == 32'h7C, "R2 tb2 rate", v, 32'h7C);
        wr(A_CFG, 32'h1FF); repeat (40) @(negedge clk);
        wr(A_CTRL, 32'h7F); repeat (64) @(negedge clk); rd(A_CTRL, v);
        chk(v == 32'h7D, "R2 tb3 rate", v, 32'h7D);

        // R8: disarmed, early write and rollover stay quiet
        wr(A_CFG, 32'h050); repeat (40) @(negedge clk);
        p0 = pulses;
        wr(A_CTRL, 32'h7F);
        chk(sys_rst_req == 0, "R8 early write disarmed", sys_rst_req, 0);
        repeat (300) @(negedge clk);
        chk(pulses == p0, "R8 rollover disarmed", pulses - p0, 0);
        rd(A_CTRL, v); chk(v[7] == 0, "R8 still disarmed", v[7], 0);

        // R7: arming write with bit 6 clear fires
        wr(A_CTRL, 32'hBF);
        chk(sys_rst_req == 1, "R7 arm and fire", sys_rst_req, 1);
        @(negedge clk);
        chk(sys_rst_req == 0, "R12 single pulse", sys_rst_req, 0);
        rd(A_CTRL, v); chk(v[7] == 1, "R4 armed", v[7], 1);

        // R6: in-window reload quiet, early reload fires
        wr(A_CTRL, 32'hFF);
        chk(sys_rst_req == 0, "R6 legal reload", sys_rst_req, 0);
        wr(A_CTRL, 32'hFF);
        chk(sys_rst_req == 1, "R6 early reload", sys_rst_req, 1);
        poll_write(7'h51, 32'hFF, hit);
        chk(hit && sys_rst_req == 1, "R6 reload at window+1", sys_rst_req, 1);
        poll_write(7'h50, 32'hFF, hit);
        chk(hit && sys_rst_req == 0, "R6 reload at window", sys_rst_req, 0);
        @(negedge clk);
        chk(sys_rst_req == 0, "R6 no late pulse", sys_rst_req, 0);
        poll_write(7'h48, 32'h7F, hit);
        chk(hit && sys_rst_req == 0, "R4 reload with bit7 0", sys_rst_req, 0);
        rd(A_CTRL, v); chk(v[7] == 1, "R4 stays armed", v[7], 1);

        // R5 R9: warning flag without enable, then timeout
        wr(A_CFG, 32'h07F);
        wr(A_STAT, 32'h0);
        wr(A_CTRL, 32'hC3);
        rd(A_STAT, v); chk(v == 0, "R11 flag cleared", v, 0);
        wait_cnt(7'h40, hit);
        rd(A_STAT, v); chk(hit && v == 1, "R9 flag at 0x40", v, 1);
        chk(early_irq == 0, "R10 irq masked", early_irq, 0);
        hit = 0;
        for (int i = 0; i < 100 && !hit; i++) begin
            @(negedge clk);
            if (sys_rst_req) hit = 1;
        end
        rd(A_CTRL, v);
        chk(hit && v[6:0] == 7'h3F, "R5 rollover fires", v[6:0], 7'h3F);
        wr(A_STAT, 32'h1); rd(A_STAT, v);
        chk(v == 1, "R11 write 1 no effect", v, 1);
        wr(A_STAT, 32'h0); rd(A_STAT, v);
        chk(v == 0, "R11 write 0 clears", v, 0);

        // R10: interrupt with enable, enable sticky
        wr(A_CFG, 32'h27F);
        wr(A_CTRL, 32'hC2);
        wait_cnt(7'h40, hit);
        chk(hit && early_irq == 1, "R10 irq raised", early_irq, 1);
        wr(A_CTRL, 32'hFF);
        chk(sys_rst_req == 0 && early_irq == 1, "R10 irq held after reload",
            {sys_rst_req, early_irq}, 1);
        wr(A_STAT, 32'h0);
        chk(early_irq == 0, "R11 irq cleared", early_irq, 0);
        wr(A_CFG, 32'h07F); rd(A_CFG, v);
        chk(v == 32'h27F, "R10 enable sticky", v, 32'h27F);

        // R1 R8: system reset mid-run restores defaults and disarms
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        rd(A_CTRL, v); chk(v == 32'h7F, "R1 ctrl after reset", v, 32'h7F);
        rd(A_CFG, v);  chk(v == 32'h7F, "R1 cfg after reset", v, 32'h7F);
        chk(early_irq == 0, "R1 irq after reset", early_irq, 0);
        wr(A_CTRL, 32'h3F);
        chk(sys_rst_req == 0, "R8 bit6 clear disarmed", sys_rst_req, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule